// File: doc/BRIEF.md
# Serial Register Write Receiver

This block takes register writes from a host over a three-wire serial port: a serial clock, a serial data line and an active-low load strobe. The strobe frames a transfer. While it is low, every rising edge of the serial clock shifts in one bit: an 8-bit register address comes first, then one or more 6-bit data words. Each complete data word becomes one register-write event for a register bank. The event carries the address and the data, and it is marked by a single-cycle valid pulse.

The serial lines are asynchronous to the system clock. Each line passes through a two-flop synchronizer, and serial clock edges are detected inside the system clock domain. Several data words may follow one address under a single low strobe. Each further word goes to the next address. Extra bits after the last complete word are dropped when the strobe rises, so a host that always sends 16-bit frames can use the port.

Top module: `sreg_write_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `wr_valid_o` is 0 and `wr_addr_o` and `wr_data_o` are all zeros.
- R2: A data bit is taken only on a rising edge of `sck_i` seen while `load_ni` is low. Serial clock edges while `load_ni` is high take no bit, cause no write and leave the next frame unaffected.
- R3: Within a frame the first 8 bits form the address and the following 6 bits form a data word. Each field is sent least significant bit first, so bit 0 of the address is the first bit of the frame.
- R4: A single write needs exactly 14 rising serial clock edges. A frame closed after only 13 edges produces no write.
- R5: Up to 2 dummy bits sent after the 14th bit, followed by the strobe rising, produce no further write.
- R6: While the strobe stays low, every further complete 6-bit word is written to the previous word's address plus one, modulo 256.
- R7: A partial data word is never written. A rising strobe discards any incomplete address or word, and the next frame starts again with a fresh address.
- R8: Each committed word gives a `wr_valid_o` pulse exactly one system clock long. `wr_addr_o` and `wr_data_o` keep their values until the next pulse.
- R9: The write pulse for a word is high in the cycle after the third rising system clock edge that follows the `sck_i` rise carrying the word's last bit. That edge count covers two synchronizer flops and one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| sdata_i | input | 1 | Serial data from host, asynchronous |
| load_ni | input | 1 | Active-low load strobe framing a transfer |
| wr_valid_o | output | 1 | One-cycle pulse per committed word |
| wr_addr_o | output | 8 | Register address of the committed word |
| wr_data_o | output | 6 | Data of the committed word |

## Verification
A bit counter that slips by one, in either phase, shows up on the first write. The word appears one edge early or late, with the address and data shifted by a bit. A burst with a missing or doubled address step shows the wrong address on its second pulse. A counter that is not cleared when the strobe rises lets a dummy bit or a partial word from one frame corrupt the address of the next frame, which is visible on the very first write after it. Latency faults move the pulse away from the third system clock edge after the serial edge, and a stuck valid shows a pulse longer than one cycle.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned DATA_W_DEF = 6;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sreg_edge.sv
module sreg_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W_DEF,
  parameter int unsigned DW = DATA_W_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_n_i,
  input  logic          sck_rise_i,
  input  logic          bit_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int unsigned MAXW  = (AW > DW) ? AW : DW;
  localparam int unsigned CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] A_LAST = CNT_W'(AW - 1);
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DW - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    sh_a_q, cur_addr_q;
  logic [DW-1:0]    sh_d_q;
  logic [AW-1:0]    sh_a_nxt;
  logic [DW-1:0]    sh_d_nxt;

  // LSB first: new bit enters at the top, first bit ends at bit 0
  assign sh_a_nxt = {bit_i, sh_a_q[AW-1:1]};
  assign sh_d_nxt = {bit_i, sh_d_q[DW-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_ADDR;
      cnt_q      <= '0;
      sh_a_q     <= '0;
      sh_d_q     <= '0;
      cur_addr_q <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (load_n_i) begin
        // strobe idle or just released: drop any partial field
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
      end else if (sck_rise_i) begin
        unique case (phase_q)
          PH_ADDR: begin
            sh_a_q <= sh_a_nxt;
            if (cnt_q == A_LAST) begin
              cur_addr_q <= sh_a_nxt;
              phase_q    <= PH_DATA;
              cnt_q      <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_DATA: begin
            sh_d_q <= sh_d_nxt;
            if (cnt_q == D_LAST) begin
              wr_valid_o <= 1'b1;
              wr_addr_o  <= cur_addr_q;
              wr_data_o  <= sh_d_nxt;
              cur_addr_q <= cur_addr_q + 1'b1;
              cnt_q      <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: phase_q <= PH_ADDR;
        endcase
      end
    end
  end
endmodule

// File: rtl/sreg_write_rx.sv
module sreg_write_rx
  import sreg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W_DEF,
  parameter int unsigned DW = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          sdata_i,
  input  logic          load_ni,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int unsigned NLINES = 3;

  logic [NLINES-1:0] raw, synced;
  logic sck_s, sdata_s, load_n_s, sck_rise;

  assign raw = {load_ni, sdata_i, sck_i};

  // strobe resets to idle (high), others low
  sreg_sync #(
    .W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(NLINES'(3'b100))
  ) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(synced)
  );

  assign sck_s    = synced[0];
  assign sdata_s  = synced[1];
  assign load_n_s = synced[2];

  sreg_edge u_sck_edge (
    .clk_i, .rst_ni, .lvl_i(sck_s), .rise_o(sck_rise)
  );

  sreg_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk_i, .rst_ni,
    .load_n_i(load_n_s),
    .sck_rise_i(sck_rise),
    .bit_i(sdata_s),
    .wr_valid_o, .wr_addr_o, .wr_data_o
  );
endmodule

// File: rtl/sreg_write_rx_chk.sv
module sreg_write_rx_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_n_s,
  input logic          wr_valid_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o
);
  logic          seen_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (load_n_s) begin
      seen_q <= 1'b0;
    end else if (wr_valid_o) begin
      seen_q <= 1'b1;
      last_q <= wr_addr_o;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !wr_valid_o);

  assert_write_needs_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !$past(load_n_s));

  assert_burst_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && seen_q) |-> (wr_addr_o == AW'(last_q + 1'b1)));

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  assert_hold_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> $stable(wr_addr_o));

  assert_hold_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> $stable(wr_data_o));
endmodule

bind sreg_write_rx sreg_write_rx_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_n_s(load_n_s),
  .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
);

// File: tb/sreg_write_rx_test.sv
module sreg_write_rx_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sck_i = 1'b0, sdata_i = 1'b0, load_ni = 1'b1;
  logic       wr_valid_o;
  logic [7:0] wr_addr_o;
  logic [5:0] wr_data_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] ev_a [64];
  logic [5:0] ev_d [64];
  int ev_n = 0;
  int run = 0, max_run = 0;
  logic [5:0] words [8];

  sreg_write_rx uut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (wr_valid_o) begin
      if (ev_n < 64) begin
        ev_a[ev_n] = wr_addr_o;
        ev_d[ev_n] = wr_data_o;
      end
      ev_n++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drive_bit(input logic b);
    sdata_i = b;
    wait_clk(HALF);
    sck_i = 1'b1;
    wait_clk(HALF);
    sck_i = 1'b0;
  endtask

  // address, nw full words from words[], then extra loose bits
  task automatic send_frame(input logic [7:0] a, input int nw, input int extra);
    load_ni = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 8; i++) drive_bit(a[i]);
    for (int w = 0; w < nw; w++)
      for (int i = 0; i < 6; i++) drive_bit(words[w][i]);
    for (int i = 0; i < extra; i++) drive_bit(i[0]);
    wait_clk(HALF);
    load_ni = 1'b1;
    wait_clk(8);
  endtask

  task automatic expect_events(input int base_n, input int n, input logic [7:0] a0,
                               input string req);
    chk(ev_n == base_n + n, req, ev_n - base_n, n);
    for (int i = 0; i < n; i++) begin
      if (base_n + i < ev_n) begin
        chk(ev_a[base_n+i] == 8'(a0 + i), req, ev_a[base_n+i], 8'(a0 + i));
        chk(ev_d[base_n+i] == words[i], req, ev_d[base_n+i], words[i]);
      end
    end
  endtask

  task automatic t_reset;
    chk(wr_valid_o == 1'b0, "R1", wr_valid_o, 0);
    chk(wr_addr_o == 8'h00, "R1", wr_addr_o, 0);
    chk(wr_data_o == 6'h00, "R1", wr_data_o, 0);
  endtask

  task automatic t_single;
    int b = ev_n;
    words[0] = 6'h2B;
    send_frame(8'hA5, 1, 0);
    expect_events(b, 1, 8'hA5, "R3");
  endtask

  task automatic t_thirteen;
    int b = ev_n;
    words[0] = 6'h3F;
    load_ni = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 8; i++) drive_bit(1'b1);
    for (int i = 0; i < 5; i++) drive_bit(1'b1);
    wait_clk(HALF);
    load_ni = 1'b1;
    wait_clk(8);
    chk(ev_n == b, "R4", ev_n - b, 0);
  endtask

  task automatic t_dummy;
    int b = ev_n;
    words[0] = 6'h15;
    send_frame(8'h3C, 1, 2);
    expect_events(b, 1, 8'h3C, "R5");
    b = ev_n;
    words[0] = 6'h0E;
    send_frame(8'h81, 1, 0);
    expect_events(b, 1, 8'h81, "R5");
  endtask

  task automatic t_burst;
    int b = ev_n;
    words[0] = 6'h01; words[1] = 6'h22; words[2] = 6'h3E; words[3] = 6'h19;
    send_frame(8'hFE, 4, 3);
    expect_events(b, 4, 8'hFE, "R6");
  endtask

  task automatic t_partial;
    int b = ev_n;
    words[0] = 6'h2A;
    send_frame(8'h77, 0, 2);
    chk(ev_n == b, "R7", ev_n - b, 0);
    words[0] = 6'h11;
    send_frame(8'h4D, 1, 0);
    expect_events(b, 1, 8'h4D, "R7");
  endtask

  task automatic t_load_high;
    int b = ev_n;
    for (int i = 0; i < 20; i++) drive_bit(i[1]);
    wait_clk(8);
    chk(ev_n == b, "R2", ev_n - b, 0);
    words[0] = 6'h24;
    send_frame(8'h5A, 1, 0);
    expect_events(b, 1, 8'h5A, "R2");
  endtask

  task automatic t_latency;
    logic [7:0] a = 8'hC3;
    logic [5:0] d = 6'h36;
    load_ni = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 8; i++) drive_bit(a[i]);
    for (int i = 0; i < 5; i++) drive_bit(d[i]);
    sdata_i = d[5];
    wait_clk(HALF);
    sck_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    chk(wr_valid_o == 1'b0, "R9", wr_valid_o, 0);
    @(posedge clk_i); @(negedge clk_i);
    chk(wr_valid_o == 1'b1, "R9", wr_valid_o, 1);
    chk(wr_data_o == d, "R9", wr_data_o, d);
    @(negedge clk_i);
    chk(wr_valid_o == 1'b0, "R8", wr_valid_o, 0);
    chk(wr_addr_o == a && wr_data_o == d, "R8", {wr_addr_o, wr_data_o}, {a, d});
    wait_clk(HALF);
    sck_i = 1'b0;
    wait_clk(HALF);
    load_ni = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    wait_clk(2);
    t_reset;
    rst_ni = 1'b1;
    wait_clk(1);
    t_reset;
    wait_clk(4);
    t_single;
    t_thirteen;
    t_dummy;
    t_burst;
    t_partial;
    t_load_high;
    t_latency;
    chk(max_run == 1, "R8", max_run, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule